// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This execution unit performs signed 32x32 multiplication and returns only the upper half of the result. It runs in three flavours: plain multiply, multiply with the accumulator added into the high word, and the accumulator in the high word minus the product. Each flavour can round by adding half of the kept word's least significant bit before the lower half is dropped.

The unit takes a 32-bit instruction word, the four condition flags and three register operand values. It decodes the register indices and exposes them so that a register file can supply the operands. It evaluates the condition field against the flags, and two cycles later returns the high word together with a destination index and a write enable. The two-stage pipeline accepts a new operation every cycle. The product is registered in the first stage. Accumulation, rounding and the final select take place in the second stage.

Top module: `hiword_mac`

## Requirements
- R1: When the accumulator field (instruction bits 15:12) equals 15, `out_data` is bits 63:32 of the signed 64-bit product of `in_opa` and `in_opb`.
- R2: When the accumulator field is not 15 and instruction bit 6 is 0, `out_data` is bits 63:32 of ((`in_acc` << 32) + product), taken modulo 2^64.
- R3: When the accumulator field is not 15 and instruction bit 6 is 1, `out_data` is bits 63:32 of ((`in_acc` << 32) - product), taken modulo 2^64.
- R4: When instruction bit 5 is 1, 0x80000000 is added to the 64-bit result (modulo 2^64) before the high word is taken.
- R5: `out_dst` equals instruction bits 19:16 of the operation that produced the result.
- R6: Condition codes in bits 31:28 pass as follows, with `in_flags` = {N,Z,C,V} in bits 3..0: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always.
- R7: An operation whose condition fails still produces `out_valid` high, with `out_wen` low.
- R8: `out_valid` rises exactly two cycles after `in_valid` is sampled, one result per accepted operation, in order, including on back-to-back cycles.
- R9: After a reset, `out_valid` and `out_wen` are low until an operation has passed through the pipeline.
- R10: Condition code 15 never passes, so `out_wen` is low for it.
- R11: `rd_idx_a`, `rd_idx_b` and `rd_idx_acc` combinationally show instruction bits 11:8, 3:0 and 15:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_instr | input | 32 | Instruction word |
| in_flags | input | 4 | Condition flags {N,Z,C,V} |
| in_opa | input | 32 | Value of register at bits 11:8 |
| in_opb | input | 32 | Value of register at bits 3:0 |
| in_acc | input | 32 | Value of register at bits 15:12 |
| rd_idx_a | output | 4 | Index of the first multiplicand register |
| rd_idx_b | output | 4 | Index of the second multiplicand register |
| rd_idx_acc | output | 4 | Index of the accumulator register |
| out_valid | output | 1 | Result present |
| out_wen | output | 1 | Result is to be written (condition passed) |
| out_dst | output | 4 | Destination register index |
| out_data | output | 32 | High word of the final result |

## Verification
Rounding and accumulate or subtract act together in the second stage. The rounding carry out of the low word must ripple into a high word that has just wrapped. The bench provokes this with products whose low half is at or above 0x80000000, combined with accumulators near the signed extremes and with subtraction of the most negative product. Each result is judged against a 64-bit reference that the bench computes independently. A full sweep of condition codes against flag patterns runs back to back, so that failing and passing conditions meet in adjacent pipeline slots.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  localparam int COND_HI = 31;
  localparam int COND_LO = 28;
  localparam int DST_HI  = 19;
  localparam int DST_LO  = 16;
  localparam int ACC_HI  = 15;
  localparam int ACC_LO  = 12;
  localparam int OPA_HI  = 11;
  localparam int OPA_LO  = 8;
  localparam int OPB_HI  = 3;
  localparam int OPB_LO  = 0;
  localparam int SUB_BIT = 6;
  localparam int RND_BIT = 5;
  localparam logic [3:0] NO_ACC_IDX = 4'hF;

  typedef struct packed {
    logic       pass;
    logic [3:0] dst;
    logic       acc_en;
    logic       sub;
    logic       rnd;
  } hwm_ctl_t;

  // flags = {N,Z,C,V}
  function automatic logic cond_ok(input logic [3:0] cond, input logic [3:0] flags);
    logic n, z, c, v;
    {n, z, c, v} = flags;
    case (cond)
      4'h0: cond_ok = z;
      4'h1: cond_ok = !z;
      4'h2: cond_ok = c;
      4'h3: cond_ok = !c;
      4'h4: cond_ok = n;
      4'h5: cond_ok = !n;
      4'h6: cond_ok = v;
      4'h7: cond_ok = !v;
      4'h8: cond_ok = c && !z;
      4'h9: cond_ok = !c || z;
      4'hA: cond_ok = (n == v);
      4'hB: cond_ok = (n != v);
      4'hC: cond_ok = !z && (n == v);
      4'hD: cond_ok = z || (n != v);
      4'hE: cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hwm_decode.sv
module hwm_decode
  import hwm_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [3:0]  flags,
  output hwm_ctl_t    ctl,
  output logic [3:0]  idx_a,
  output logic [3:0]  idx_b,
  output logic [3:0]  idx_acc
);
  always_comb begin
    idx_a      = instr[OPA_HI:OPA_LO];
    idx_b      = instr[OPB_HI:OPB_LO];
    idx_acc    = instr[ACC_HI:ACC_LO];
    ctl.pass   = cond_ok(instr[COND_HI:COND_LO], flags);
    ctl.dst    = instr[DST_HI:DST_LO];
    ctl.acc_en = (instr[ACC_HI:ACC_LO] != NO_ACC_IDX);
    ctl.sub    = instr[SUB_BIT];
    ctl.rnd    = instr[RND_BIT];
  end
endmodule

// File: rtl/hwm_mul_stage.sv
module hwm_mul_stage
  import hwm_pkg::*;
#(
  parameter int DW = 32,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  hwm_ctl_t      in_ctl,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] acc,
  output logic          s1_valid,
  output hwm_ctl_t      s1_ctl,
  output logic [PW-1:0] s1_prod,
  output logic [DW-1:0] s1_acc
);
  logic signed [PW-1:0] prod_c;

  always_comb prod_c = PW'($signed(opa)) * PW'($signed(opb));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ctl   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_ctl   <= in_ctl;
    end
    s1_prod <= prod_c;
    s1_acc  <= acc;
  end
endmodule

// File: rtl/hwm_acc_stage.sv
module hwm_acc_stage
  import hwm_pkg::*;
#(
  parameter int DW = 32,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  hwm_ctl_t      s1_ctl,
  input  logic [PW-1:0] s1_prod,
  input  logic [DW-1:0] s1_acc,
  output logic          out_valid,
  output logic          out_wen,
  output logic [3:0]    out_dst,
  output logic [DW-1:0] out_data
);
  localparam logic [PW-1:0] HALF_LSB = PW'(1) << (DW - 1);

  function automatic logic [PW-1:0] combine(
    input logic [PW-1:0] prod, input logic [DW-1:0] accv,
    input logic acc_en, input logic sub, input logic rnd);
    logic [PW-1:0] hi, r;
    hi = {accv, {DW{1'b0}}};
    if (!acc_en)  r = prod;
    else if (sub) r = hi - prod;
    else          r = hi + prod;
    if (rnd) r = r + HALF_LSB;
    return r;
  endfunction

  logic [PW-1:0] full_c;
  always_comb full_c = combine(s1_prod, s1_acc, s1_ctl.acc_en, s1_ctl.sub, s1_ctl.rnd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_wen   <= s1_valid && s1_ctl.pass;
    end
    out_dst  <= s1_ctl.dst;
    out_data <= full_c[PW-1:DW];
  end
endmodule

// File: rtl/hiword_mac.sv
module hiword_mac
  import hwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_instr,
  input  logic [3:0]    in_flags,
  input  logic [DW-1:0] in_opa,
  input  logic [DW-1:0] in_opb,
  input  logic [DW-1:0] in_acc,
  output logic [3:0]    rd_idx_a,
  output logic [3:0]    rd_idx_b,
  output logic [3:0]    rd_idx_acc,
  output logic          out_valid,
  output logic          out_wen,
  output logic [3:0]    out_dst,
  output logic [DW-1:0] out_data
);
  localparam int PW = 2 * DW;

  hwm_ctl_t      dec_ctl;
  hwm_ctl_t      s1_ctl;
  logic          s1_valid;
  logic [PW-1:0] s1_prod;
  logic [DW-1:0] s1_acc;
  // named events for the checker
  logic          s1_wen;
  logic [3:0]    s1_dst;

  hwm_decode u_dec (
    .instr(in_instr), .flags(in_flags), .ctl(dec_ctl),
    .idx_a(rd_idx_a), .idx_b(rd_idx_b), .idx_acc(rd_idx_acc)
  );

  hwm_mul_stage #(.DW(DW)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(dec_ctl),
    .opa(in_opa), .opb(in_opb), .acc(in_acc),
    .s1_valid(s1_valid), .s1_ctl(s1_ctl), .s1_prod(s1_prod), .s1_acc(s1_acc)
  );

  hwm_acc_stage #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_ctl(s1_ctl),
    .s1_prod(s1_prod), .s1_acc(s1_acc),
    .out_valid(out_valid), .out_wen(out_wen), .out_dst(out_dst), .out_data(out_data)
  );

  always_comb begin
    s1_wen = s1_valid && s1_ctl.pass;
    s1_dst = s1_ctl.dst;
  end
endmodule

// File: rtl/hwm_checker.sv
module hwm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic        s1_valid,
  input logic        s1_wen,
  input logic [3:0]  s1_dst,
  input logic        out_valid,
  input logic        out_wen,
  input logic [3:0]  out_dst
);
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[31:28] == 4'hE) |=> s1_wen); // R6
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_instr[31:28] == 4'hF) |=> !s1_wen); // R10
  AST_WEN_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_valid); // R7
  AST_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid); // R8
  AST_DST_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (out_dst == $past(s1_dst))); // R5
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[19:16] == 4'h0) |=> (s1_valid && s1_dst == 4'h0)); // R5
endmodule

bind hiword_mac hwm_checker u_hwm_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
  .s1_valid(s1_valid), .s1_wen(s1_wen), .s1_dst(s1_dst),
  .out_valid(out_valid), .out_wen(out_wen), .out_dst(out_dst)
);

// File: tb/test_hiword_mac.sv
module test_hiword_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [3:0]  in_flags = '0;
  logic [31:0] in_opa = '0, in_opb = '0, in_acc = '0;
  logic [3:0]  rd_idx_a, rd_idx_b, rd_idx_acc;
  logic        out_valid, out_wen;
  logic [3:0]  out_dst;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic        wen;
    logic [3:0]  dst;
    logic [31:0] data;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  hiword_mac i_hiword_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_flags(in_flags), .in_opa(in_opa), .in_opb(in_opb), .in_acc(in_acc),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .rd_idx_acc(rd_idx_acc),
    .out_valid(out_valid), .out_wen(out_wen), .out_dst(out_dst), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference: base test on cond[3:1], inverted by cond[0]
  function automatic bit ref_pass(input logic [3:0] cond, input logic [3:0] f);
    bit n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    unique case (cond[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return cond[0] ? !base : base;
  endfunction

  function automatic logic [31:0] ref_data(input logic [31:0] a, b, acc,
                                           input bit use_acc, sub, rnd);
    longint p, r;
    p = longint'($signed(a)) * longint'($signed(b));
    r = p;
    if (use_acc) r = sub ? ((longint'(acc) << 32) - p) : ((longint'(acc) << 32) + p);
    if (rnd) r = r + 64'sh8000_0000;
    return r[63:32];
  endfunction

  // drive one operation at a negedge; leaves in_valid high for one cycle
  task automatic issue(input logic [3:0] cond, input logic [3:0] flags,
                       input logic [3:0] rd, ra, rm, rn, input bit sub, rnd,
                       input logic [31:0] a, b, acc, input string tag);
    exp_t e;
    in_valid = 1'b1;
    in_instr = {cond, 4'b0111, 4'b0101, rd, ra, rm, 1'b0, sub, rnd, 1'b1, rn};
    in_flags = flags;
    in_opa = a; in_opb = b; in_acc = acc;
    e.wen  = ref_pass(cond, flags);
    e.dst  = rd;
    e.data = ref_data(a, b, acc, ra != 4'hF, sub, rnd);
    e.due  = cyc + 2;
    e.tag  = tag;
    sb.push_back(e);
    #1;
    check(rd_idx_a == rm && rd_idx_b == rn && rd_idx_acc == ra, "R11",
          {52'd0, rd_idx_a, rd_idx_b, rd_idx_acc}, {52'd0, rm, rn, ra});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_instr = '0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected result", 64'(out_data), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, "R8 latency", 64'(cyc), 64'(e.due));
        check(out_wen == e.wen, {e.tag, " wen"}, 64'(out_wen), 64'(e.wen));
        check(out_dst == e.dst, "R5 dst", 64'(out_dst), 64'(e.dst));
        check(out_data == e.data, {e.tag, " data"}, 64'(out_data), 64'(e.data));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_wen == 1'b0, "R9 reset", {out_valid, out_wen}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_wen == 1'b0, "R9 after reset", {out_valid, out_wen}, 2'b00);

    // R1 plain high-word multiply
    issue(4'hE, 4'h0, 4'd1, 4'hF, 4'd2, 4'd3, 0, 0, 32'h8000_0000, 32'h8000_0000, 32'hDEAD_BEEF, "R1");
    issue(4'hE, 4'h0, 4'd2, 4'hF, 4'd4, 4'd5, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, "R1");
    issue(4'hE, 4'h0, 4'd3, 4'hF, 4'd6, 4'd7, 1, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1, "R1");
    idle(2);
    // R4 rounding, with carry and wrap
    issue(4'hE, 4'h0, 4'd4, 4'hF, 4'd1, 4'd2, 0, 1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, "R4");
    issue(4'hE, 4'h0, 4'd5, 4'hF, 4'd1, 4'd2, 0, 1, 32'h0001_0000, 32'h0000_8000, 32'h0, "R4");
    issue(4'hE, 4'h0, 4'd6, 4'hF, 4'd1, 4'd2, 0, 1, 32'h0001_0000, 32'h0000_7FFF, 32'h0, "R4");
    // R2 accumulate
    issue(4'hE, 4'h0, 4'd7, 4'd9, 4'd1, 4'd2, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2");
    issue(4'hE, 4'h0, 4'd8, 4'd0, 4'd1, 4'd2, 0, 1, 32'hFFFF_0000, 32'h0000_8001, 32'h0000_0010, "R2 R4");
    // R3 subtract, incl. most negative product and wrap
    issue(4'hE, 4'h0, 4'd9, 4'd3, 4'd1, 4'd2, 1, 0, 32'h8000_0000, 32'h8000_0000, 32'h0, "R3");
    issue(4'hE, 4'h0, 4'd10, 4'd3, 4'd1, 4'd2, 1, 1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, "R3 R4");
    issue(4'hE, 4'h0, 4'd11, 4'd14, 4'd1, 4'd2, 1, 1, 32'h0000_0003, 32'h5555_5555, 32'h7FFF_FFFF, "R3 R4");
    idle(3);
    // mixed random back-to-back
    for (int i = 0; i < 64; i++) begin
      logic [3:0] ra;
      ra = (i % 3 == 0) ? 4'hF : 4'(i);
      issue(4'hE, 4'h0, 4'(i), ra, 4'(i + 1), 4'(i + 2), i[0], i[1],
            $urandom, $urandom, $urandom, ra == 4'hF ? "R1 mix" : "R2 R3 mix");
    end
    idle(1);
    // R6 R7 R10 full condition sweep against all flag patterns, back to back
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        issue(4'(c), 4'(f), 4'(c), 4'hF, 4'd1, 4'd2, 0, 0, 32'(c * 77 + 1), 32'(f + 3), 32'h0,
              c == 15 ? "R10" : "R6 R7");
      end
    end
    idle(4);
    check(sb.size() == 0, "R8 drained", 64'(sb.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule